// File: doc/BRIEF.md
# Paged Network Controller Register File

This block is the byte-wide register file that a host processor sees on a simple Ethernet controller. The host presents a 4-bit offset with a write strobe, or just the offset for a read. Bits 7:6 of the command register pick one of four pages, so sixteen offsets reach a larger set of registers. Offset 0 is the command register on every page. At several offsets a read returns a different register from the one a write reaches.

The block stores the ring buffer start and stop pages, the boundary pointer, the transmit page and byte count, the remote DMA address and count, and the data configuration byte. These go out to the datapath. It also stores the current receive page, a six-byte station address and an eight-byte multicast mask, which the host reads back. Interrupt status bits are set by an event input from the rest of the controller and by the block's own commands. The host clears them by writing ones, and a mask register gates them onto one level interrupt.

A transmit command produces a one-cycle request that carries the frame's byte address and length. Sending the frame is done elsewhere.

Top module: `paged_nic_regs`

## Requirements
- R1: After reset the interrupt status reads 0x80 and the command register reads 0x00, so page 0 is selected. Every other readable register reads 0x00, irq is low and tx_req is low.
- R2: Bits 7:6 of the command register select the page. Offset 0 reads and writes the command register on all four pages.
- R3: Page 0 write map: offset 1 is ring start page, 2 is ring stop page, 3 is boundary, 4 is transmit page, 5/6 are transmit count low/high, 7 is interrupt status, 8/9 are remote address low/high, 10/11 are remote count low/high, 14 is data config and 15 is interrupt mask. Page 0 reads return boundary at offset 3, transmit status at offset 4 and interrupt status at offset 7.
- R4: On page 1, offsets 1 to 6 are the station address bytes 0 to 5, offset 7 is the current receive page, and offsets 8 to 15 are multicast bytes 0 to 7. All of these can be read and written.
- R5: Every read offset not named in R2 to R4, including every nonzero offset on pages 2 and 3, returns 0x00. Writes to unnamed offsets change no register.
- R6: A write to interrupt status clears each bit written as 1. When a set from any source lands in the same cycle as a clear, the set wins.
- R7: Each bit of ev_set that is 1 in a cycle sets the matching interrupt status bit at the next clock edge.
- R8: irq is high exactly when the bitwise AND of interrupt status and interrupt mask is nonzero. It follows a status or mask change from the clock edge that changes that register.
- R9: A command write with bit 1 (start) and bit 2 (transmit) set makes tx_req high for the following cycle. In that cycle tx_addr is {transmit page, 8'h00} and tx_len is the 16-bit transmit count. The same edge sets transmit status to 0x01 and status bit 1. A command write without start sends nothing.
- R10: A command write with start set, bit 3 (remote read) or bit 4 (remote write) set, and a remote count of zero sets status bit 6. A nonzero count leaves bit 6 alone.
- R11: ring_start_addr and ring_stop_addr are the stored page numbers with eight zero bits appended. rdma_addr, rdma_count and data_cfg show the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for addr on the current page |
| ev_set | input | 8 | Status set events from the controller |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | One-cycle transmit request |
| tx_addr | output | 16 | Frame byte address |
| tx_len | output | 16 | Frame byte length |
| ring_start_addr | output | 16 | Ring start byte address |
| ring_stop_addr | output | 16 | Ring stop byte address |
| rdma_addr | output | 16 | Remote DMA address |
| rdma_count | output | 16 | Remote DMA count |
| data_cfg | output | 8 | Data configuration |

## Verification
The hardest case to reach from the ports is a clock edge where a status bit is both set and cleared. The set can come from ev_set, a transmit command or a zero-count remote command, and it must beat the write-one clear. The bench forces this with a directed clear that carries a matching ev_set. Random traffic then mixes status writes with random events. Commands with random page bits also steer writes onto pages 2 and 3, and a full register model shows they left nothing behind.

// File: rtl/paged_nic_pkg.sv
package paged_nic_pkg;

  // Command bit positions
  localparam int CB_STOP  = 0;
  localparam int CB_START = 1;
  localparam int CB_XMIT  = 2;
  localparam int CB_RRD   = 3;
  localparam int CB_RWR   = 4;

  // Interrupt status bit positions
  localparam int IB_RX_OK     = 0;
  localparam int IB_TX_OK     = 1;
  localparam int IB_RX_ERR    = 2;
  localparam int IB_TX_ERR    = 3;
  localparam int IB_OVERWRITE = 4;
  localparam int IB_COUNTERS  = 5;
  localparam int IB_RDMA_DONE = 6;
  localparam int IB_RESET     = 7;

  typedef enum logic [4:0] {
    W_NONE, W_CMD, W_RSTART, W_RSTOP, W_BNDRY, W_TPG, W_TCLO, W_TCHI,
    W_ISR, W_RALO, W_RAHI, W_RCLO, W_RCHI, W_DCFG, W_IMR,
    W_STA, W_CURPG, W_MCAST
  } wsel_e;

  typedef enum logic [2:0] {
    R_ZERO, R_CMD, R_BNDRY, R_TSR, R_ISR, R_STA, R_CURPG, R_MCAST
  } rsel_e;

endpackage

// File: rtl/paged_nic_byte_reg.sv
module paged_nic_byte_reg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_r;
    if (en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RST_VAL;
    else        q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/paged_nic_dec.sv
module paged_nic_dec
  import paged_nic_pkg::*;
#(
  parameter int OFFS_W = 4,
  parameter int PAGE_W = 2,
  parameter int N_STA  = 6,
  parameter int N_MC   = 8,
  parameter int IDX_W  = 3
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [OFFS_W-1:0] offs,
  output wsel_e             wsel,
  output rsel_e             rsel,
  output logic [IDX_W-1:0]  idx
);

  localparam int STA_LO  = 1;
  localparam int STA_HI  = STA_LO + N_STA - 1;
  localparam int CUR_OFF = STA_HI + 1;
  localparam int MC_LO   = CUR_OFF + 1;
  localparam int MC_HI   = MC_LO + N_MC - 1;

  int o;

  always_comb begin
    o    = int'(offs);
    wsel = W_NONE;
    rsel = R_ZERO;
    idx  = '0;
    if (o == 0) begin
      wsel = W_CMD;
      rsel = R_CMD;
    end else if (page == PAGE_W'(0)) begin
      case (o)
        1:  wsel = W_RSTART;
        2:  wsel = W_RSTOP;
        3:  begin wsel = W_BNDRY; rsel = R_BNDRY; end
        4:  begin wsel = W_TPG;   rsel = R_TSR;   end
        5:  wsel = W_TCLO;
        6:  wsel = W_TCHI;
        7:  begin wsel = W_ISR;   rsel = R_ISR;   end
        8:  wsel = W_RALO;
        9:  wsel = W_RAHI;
        10: wsel = W_RCLO;
        11: wsel = W_RCHI;
        14: wsel = W_DCFG;
        15: wsel = W_IMR;
        default: wsel = W_NONE;
      endcase
    end else if (page == PAGE_W'(1)) begin
      if (o >= STA_LO && o <= STA_HI) begin
        wsel = W_STA;
        rsel = R_STA;
        idx  = IDX_W'(o - STA_LO);
      end else if (o == CUR_OFF) begin
        wsel = W_CURPG;
        rsel = R_CURPG;
      end else if (o >= MC_LO && o <= MC_HI) begin
        wsel = W_MCAST;
        rsel = R_MCAST;
        idx  = IDX_W'(o - MC_LO);
      end
    end
  end

endmodule

// File: rtl/paged_nic_cmd.sv
module paged_nic_cmd
  import paged_nic_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_we,
  input  logic [W-1:0]   wdata,
  input  logic [W-1:0]   tpg,
  input  logic [2*W-1:0] tcnt,
  input  logic [2*W-1:0] rcnt,
  output logic [W-1:0]   cmd_q,
  output logic [W-1:0]   tsr_q,
  output logic           tx_req,
  output logic [2*W-1:0] tx_addr,
  output logic [2*W-1:0] tx_len,
  output logic           tx_set,
  output logic           rdma_set
);

  logic           go, xmit, rdz;
  logic [W-1:0]   cmd_r, cmd_d, tsr_r, tsr_d;
  logic           req_r, req_d;
  logic [2*W-1:0] txa_r, txa_d, txl_r, txl_d;

  always_comb begin
    go    = cmd_we && wdata[CB_START];
    xmit  = go && wdata[CB_XMIT];
    rdz   = go && (wdata[CB_RRD] || wdata[CB_RWR]) && (rcnt == '0);
    cmd_d = cmd_r;
    tsr_d = tsr_r;
    txa_d = txa_r;
    txl_d = txl_r;
    req_d = xmit;
    if (cmd_we) cmd_d = wdata;
    if (xmit) begin
      tsr_d = W'(1);
      txa_d = {tpg, {W{1'b0}}};
      txl_d = tcnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_r <= '0;
      tsr_r <= '0;
      req_r <= 1'b0;
      txa_r <= '0;
      txl_r <= '0;
    end else begin
      cmd_r <= cmd_d;
      tsr_r <= tsr_d;
      req_r <= req_d;
      txa_r <= txa_d;
      txl_r <= txl_d;
    end
  end

  assign cmd_q    = cmd_r;
  assign tsr_q    = tsr_r;
  assign tx_req   = req_r;
  assign tx_addr  = txa_r;
  assign tx_len   = txl_r;
  assign tx_set   = xmit;
  assign rdma_set = rdz;

endmodule

// File: rtl/paged_nic_irq.sv
module paged_nic_irq #(
  parameter int           W       = 8,
  parameter logic [W-1:0] ISR_RST = 8'h80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         isr_we,
  input  logic         imr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] isr_q,
  output logic [W-1:0] imr_q,
  output logic         irq
);

  logic [W-1:0] isr_r, isr_d, imr_r, imr_d;

  always_comb begin
    isr_d = isr_r;
    imr_d = imr_r;
    if (isr_we) isr_d = isr_r & ~wdata;
    isr_d = isr_d | set_vec;
    if (imr_we) imr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_r <= ISR_RST;
      imr_r <= '0;
    end else begin
      isr_r <= isr_d;
      imr_r <= imr_d;
    end
  end

  assign isr_q = isr_r;
  assign imr_q = imr_r;
  assign irq   = |(isr_r & imr_r);

endmodule

// File: rtl/paged_nic_regs.sv
module paged_nic_regs
  import paged_nic_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OFFS_W = 4,
  parameter int PAGE_W = 2,
  parameter int N_STA  = 6,
  parameter int N_MC   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [OFFS_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  input  logic [BYTE_W-1:0]   ev_set,
  output logic                irq,
  output logic                tx_req,
  output logic [2*BYTE_W-1:0] tx_addr,
  output logic [2*BYTE_W-1:0] tx_len,
  output logic [2*BYTE_W-1:0] ring_start_addr,
  output logic [2*BYTE_W-1:0] ring_stop_addr,
  output logic [2*BYTE_W-1:0] rdma_addr,
  output logic [2*BYTE_W-1:0] rdma_count,
  output logic [BYTE_W-1:0]   data_cfg
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int N_MAX  = (N_MC > N_STA) ? N_MC : N_STA;
  localparam int IDX_W  = (N_MAX > 1) ? $clog2(N_MAX) : 1;

  wsel_e             wsel;
  rsel_e             rsel;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] cmd_q, tsr_q, isr_q, imr_q;
  logic [PAGE_W-1:0] page;
  logic              tx_set, rdma_set;
  logic [BYTE_W-1:0] set_vec;

  logic [BYTE_W-1:0] start_q, stop_q, bnd_q, tpg_q, tclo_q, tchi_q;
  logic [BYTE_W-1:0] ralo_q, rahi_q, rclo_q, rchi_q, dcfg_q, cur_q;
  logic [BYTE_W-1:0] sta_q [N_STA];
  logic [BYTE_W-1:0] mc_q  [N_MC];

  assign page = cmd_q[BYTE_W-1 -: PAGE_W];

  paged_nic_dec #(
    .OFFS_W(OFFS_W), .PAGE_W(PAGE_W), .N_STA(N_STA), .N_MC(N_MC), .IDX_W(IDX_W)
  ) u_dec (
    .page(page), .offs(addr), .wsel(wsel), .rsel(rsel), .idx(idx)
  );

  paged_nic_cmd #(.W(BYTE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(wr_en && wsel == W_CMD), .wdata(wdata),
    .tpg(tpg_q), .tcnt({tchi_q, tclo_q}), .rcnt({rchi_q, rclo_q}),
    .cmd_q(cmd_q), .tsr_q(tsr_q), .tx_req(tx_req),
    .tx_addr(tx_addr), .tx_len(tx_len),
    .tx_set(tx_set), .rdma_set(rdma_set)
  );

  always_comb begin
    set_vec               = ev_set;
    set_vec[IB_TX_OK]     = ev_set[IB_TX_OK] | tx_set;
    set_vec[IB_RDMA_DONE] = ev_set[IB_RDMA_DONE] | rdma_set;
  end

  paged_nic_irq #(.W(BYTE_W), .ISR_RST(BYTE_W'(1) << IB_RESET)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .isr_we(wr_en && wsel == W_ISR), .imr_we(wr_en && wsel == W_IMR),
    .wdata(wdata), .set_vec(set_vec),
    .isr_q(isr_q), .imr_q(imr_q), .irq(irq)
  );

  paged_nic_byte_reg #(.W(BYTE_W)) u_start (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_RSTART), .d(wdata), .q(start_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_stop  (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_RSTOP),  .d(wdata), .q(stop_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_bnd   (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_BNDRY),  .d(wdata), .q(bnd_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_tpg   (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_TPG),    .d(wdata), .q(tpg_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_tclo  (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_TCLO),   .d(wdata), .q(tclo_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_tchi  (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_TCHI),   .d(wdata), .q(tchi_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_ralo  (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_RALO),   .d(wdata), .q(ralo_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_rahi  (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_RAHI),   .d(wdata), .q(rahi_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_rclo  (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_RCLO),   .d(wdata), .q(rclo_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_rchi  (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_RCHI),   .d(wdata), .q(rchi_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_dcfg  (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_DCFG),   .d(wdata), .q(dcfg_q));
  paged_nic_byte_reg #(.W(BYTE_W)) u_cur   (.clk(clk), .rst_n(rst_n), .en(wr_en && wsel == W_CURPG),  .d(wdata), .q(cur_q));

  for (genvar g = 0; g < N_STA; g++) begin : g_sta
    paged_nic_byte_reg #(.W(BYTE_W)) u_b (
      .clk(clk), .rst_n(rst_n),
      .en(wr_en && wsel == W_STA && idx == IDX_W'(g)),
      .d(wdata), .q(sta_q[g])
    );
  end

  for (genvar g = 0; g < N_MC; g++) begin : g_mc
    paged_nic_byte_reg #(.W(BYTE_W)) u_b (
      .clk(clk), .rst_n(rst_n),
      .en(wr_en && wsel == W_MCAST && idx == IDX_W'(g)),
      .d(wdata), .q(mc_q[g])
    );
  end

  always_comb begin
    case (rsel)
      R_CMD:   rdata = cmd_q;
      R_BNDRY: rdata = bnd_q;
      R_TSR:   rdata = tsr_q;
      R_ISR:   rdata = isr_q;
      R_STA:   rdata = sta_q[idx];
      R_CURPG: rdata = cur_q;
      R_MCAST: rdata = mc_q[idx];
      default: rdata = '0;
    endcase
  end

  assign ring_start_addr = {start_q, {BYTE_W{1'b0}}};
  assign ring_stop_addr  = {stop_q,  {BYTE_W{1'b0}}};
  assign rdma_addr       = {rahi_q, ralo_q};
  assign rdma_count      = {rchi_q, rclo_q};
  assign data_cfg        = dcfg_q;

  logic unused_ok;
  assign unused_ok = ^{imr_q, WORD_W'(0)};

endmodule

// File: rtl/paged_nic_regs_chk.sv
module paged_nic_regs_chk #(
  parameter int BYTE_W = 8,
  parameter int OFFS_W = 4,
  parameter int PAGE_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [OFFS_W-1:0]   addr,
  input logic [BYTE_W-1:0]   wdata,
  input logic [PAGE_W-1:0]   page,
  input logic [BYTE_W-1:0]   ev_set,
  input logic [BYTE_W-1:0]   rdata,
  input logic                irq,
  input logic                tx_req,
  input logic [2*BYTE_W-1:0] tx_addr,
  input logic [BYTE_W-1:0]   tsr,
  input logic [BYTE_W-1:0]   isr,
  input logic [BYTE_W-1:0]   imr,
  input logic [2*BYTE_W-1:0] rcnt
);

  AST_TX_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(wr_en && addr == '0 && wdata[1] && wdata[2])); // R9

  AST_TX_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tsr == BYTE_W'(1) && isr[1])); // R9

  AST_TX_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_addr[BYTE_W-1:0] == '0)); // R9

  AST_ZERO_RDMA_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wdata[1] && (wdata[3] || wdata[4]) && rcnt == '0) |=> isr[6]); // R10

  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '0) |-> !irq); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && page == '0 && addr == OFFS_W'(7) && ev_set == '0) |=> ((isr & $past(wdata) & ~BYTE_W'(8'h42)) == '0)); // R6

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((isr & $past(ev_set)) == $past(ev_set))); // R7

  AST_HIGH_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (page[PAGE_W-1] && addr != '0) |-> (rdata == '0)); // R5

endmodule

bind paged_nic_regs paged_nic_regs_chk #(
  .BYTE_W(BYTE_W), .OFFS_W(OFFS_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .page(page), .ev_set(ev_set), .rdata(rdata), .irq(irq), .tx_req(tx_req),
  .tx_addr(tx_addr), .tsr(tsr_q), .isr(isr_q), .imr(imr_q),
  .rcnt(rdma_count)
);

// File: tb/paged_nic_regs_test.sv
`timescale 1ns/1ps
module paged_nic_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  ev_set = 8'h00;
  logic [7:0]  rdata;
  logic        irq, tx_req;
  logic [15:0] tx_addr, tx_len, ring_start_addr, ring_stop_addr, rdma_addr, rdma_count;
  logic [7:0]  data_cfg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0]  m_cmd, m_bnd, m_tsr, m_isr, m_imr, m_cur, m_start, m_stop, m_tpg, m_dcfg;
  logic [15:0] m_tcnt, m_rcnt, m_rsar;
  logic [7:0]  m_sta [6];
  logic [7:0]  m_mc  [8];
  logic        e_tx;
  logic [15:0] e_txa, e_txl;

  paged_nic_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_set(ev_set), .irq(irq), .tx_req(tx_req),
    .tx_addr(tx_addr), .tx_len(tx_len), .ring_start_addr(ring_start_addr),
    .ring_stop_addr(ring_stop_addr), .rdma_addr(rdma_addr),
    .rdma_count(rdma_count), .data_cfg(data_cfg)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_cmd = 0; m_bnd = 0; m_tsr = 0; m_isr = 8'h80; m_imr = 0; m_cur = 0;
    m_start = 0; m_stop = 0; m_tpg = 0; m_dcfg = 0;
    m_tcnt = 0; m_rcnt = 0; m_rsar = 0;
    for (int i = 0; i < 6; i++) m_sta[i] = 0;
    for (int i = 0; i < 8; i++) m_mc[i] = 0;
  endfunction

  function automatic void m_write(input logic [3:0] a, input logic [7:0] d, input logic [7:0] s);
    logic [7:0] setv = s;
    logic [7:0] clr = 8'h00;
    logic [1:0] pg = m_cmd[7:6];
    e_tx = 1'b0;
    if (a == 4'd0) begin
      if (d[1] && d[2]) begin
        e_tx = 1'b1; e_txa = {m_tpg, 8'h00}; e_txl = m_tcnt;
        m_tsr = 8'h01; setv = setv | 8'h02;
      end
      if (d[1] && (d[3] || d[4]) && m_rcnt == 16'd0) setv = setv | 8'h40;
      m_cmd = d;
    end else if (pg == 2'd0) begin
      case (a)
        4'd1:  m_start = d;
        4'd2:  m_stop = d;
        4'd3:  m_bnd = d;
        4'd4:  m_tpg = d;
        4'd5:  m_tcnt[7:0] = d;
        4'd6:  m_tcnt[15:8] = d;
        4'd7:  clr = d;
        4'd8:  m_rsar[7:0] = d;
        4'd9:  m_rsar[15:8] = d;
        4'd10: m_rcnt[7:0] = d;
        4'd11: m_rcnt[15:8] = d;
        4'd14: m_dcfg = d;
        4'd15: m_imr = d;
        default: ;
      endcase
    end else if (pg == 2'd1) begin
      if (a <= 4'd6) m_sta[a - 4'd1] = d;
      else if (a == 4'd7) m_cur = d;
      else m_mc[a - 4'd8] = d;
    end
    m_isr = (m_isr & ~clr) | setv;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic [1:0] pg = m_cmd[7:6];
    if (a == 4'd0) return m_cmd;
    if (pg == 2'd0) begin
      if (a == 4'd3) return m_bnd;
      if (a == 4'd4) return m_tsr;
      if (a == 4'd7) return m_isr;
      return 8'h00;
    end
    if (pg == 2'd1) begin
      if (a <= 4'd6) return m_sta[a - 4'd1];
      if (a == 4'd7) return m_cur;
      return m_mc[a - 4'd8];
    end
    return 8'h00;
  endfunction

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d, input logic [7:0] s, input string tag);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; ev_set = s;
    m_write(a, d, s);
    @(negedge clk);
    wr_en = 1'b0; ev_set = 8'h00;
    chk({tag, " R9 tx_req"}, {15'd0, tx_req}, {15'd0, e_tx});
    if (e_tx) begin
      chk({tag, " R9 tx_addr"}, tx_addr, e_txa);
      chk({tag, " R9 tx_len"}, tx_len, e_txl);
    end
    chk({tag, " R8 irq"}, {15'd0, irq}, {15'd0, |(m_isr & m_imr)});
    chk({tag, " R11 ring_start"}, ring_start_addr, {m_start, 8'h00});
    chk({tag, " R11 ring_stop"}, ring_stop_addr, {m_stop, 8'h00});
    chk({tag, " R11 rdma_addr"}, rdma_addr, m_rsar);
    chk({tag, " R11 rdma_count"}, rdma_count, m_rcnt);
    chk({tag, " R11 data_cfg"}, {8'h00, data_cfg}, {8'h00, m_dcfg});
  endtask

  task automatic do_rd(input logic [3:0] a, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, {8'h00, rdata}, {8'h00, m_read(a)});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240607);
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 16; a++) do_rd(4'(a), "R1 reset read page0");
    chk("R1 irq after reset", {15'd0, irq}, 16'd0);
    chk("R1 tx_req after reset", {15'd0, tx_req}, 16'd0);

    // R8, R6: mask and write-one-clear
    do_wr(4'd15, 8'h80, 8'h00, "R8 mask reset bit");
    chk("R8 irq follows mask", {15'd0, irq}, 16'd1);
    do_wr(4'd7, 8'h80, 8'h00, "R6 clear reset bit");
    do_rd(4'd7, "R6 status after clear");

    // R9: transmit
    do_wr(4'd4, 8'h40, 8'h00, "R3 tpg");
    do_wr(4'd5, 8'hDC, 8'h00, "R3 tcnt lo");
    do_wr(4'd6, 8'h05, 8'h00, "R3 tcnt hi");
    do_wr(4'd15, 8'h02, 8'h00, "R3 imr");
    do_wr(4'd0, 8'h06, 8'h00, "R9 start+transmit");
    do_rd(4'd4, "R9 transmit status");
    do_rd(4'd7, "R9 tx ok bit");
    do_wr(4'd7, 8'hFF, 8'h00, "R6 clear all");
    do_wr(4'd0, 8'h04, 8'h00, "R9 transmit without start");
    do_rd(4'd7, "R9 no status without start");

    // R10: zero count remote DMA
    do_wr(4'd0, 8'h0A, 8'h00, "R10 remote read zero count");
    do_rd(4'd7, "R10 rdma done set");
    do_wr(4'd7, 8'h40, 8'h00, "R6 clear rdma done");
    do_wr(4'd10, 8'h10, 8'h00, "R3 rcnt lo");
    do_wr(4'd0, 8'h12, 8'h00, "R10 remote write nonzero");
    do_rd(4'd7, "R10 rdma done not set");

    // R11 and R3 ring registers
    do_wr(4'd1, 8'h46, 8'h00, "R11 start page");
    do_wr(4'd2, 8'h80, 8'h00, "R11 stop page");
    do_wr(4'd8, 8'h34, 8'h00, "R11 rsar lo");
    do_wr(4'd9, 8'h12, 8'h00, "R11 rsar hi");
    do_wr(4'd14, 8'h49, 8'h00, "R11 dcfg");
    do_wr(4'd3, 8'h4C, 8'h00, "R3 boundary");
    do_rd(4'd3, "R3 boundary read");

    // R4: page 1
    do_wr(4'd0, 8'h42, 8'h00, "R2 select page1");
    do_rd(4'd0, "R2 command readback");
    for (int a = 1; a < 16; a++) do_wr(4'(a), 8'(8'h10 + a * 7), 8'h00, "R4 page1 write");
    for (int a = 1; a < 16; a++) do_rd(4'(a), "R4 page1 read");

    // R5: pages 2 and 3 write nothing
    do_wr(4'd0, 8'h82, 8'h00, "R2 select page2");
    for (int a = 1; a < 16; a++) do_wr(4'(a), 8'hA5, 8'h00, "R5 page2 write");
    for (int a = 0; a < 16; a++) do_rd(4'(a), "R5 page2 read");
    do_wr(4'd0, 8'hC2, 8'h00, "R2 select page3");
    for (int a = 0; a < 16; a++) do_rd(4'(a), "R5 page3 read");
    do_wr(4'd0, 8'h42, 8'h00, "R2 back to page1");
    for (int a = 1; a < 16; a++) do_rd(4'(a), "R5 page1 intact");
    do_wr(4'd0, 8'h02, 8'h00, "R2 back to page0");
    for (int a = 0; a < 16; a++) do_rd(4'(a), "R5 page0 intact");
    do_wr(4'd12, 8'hFF, 8'h00, "R5 unmapped write 12");
    do_wr(4'd13, 8'hFF, 8'h00, "R5 unmapped write 13");
    for (int a = 0; a < 16; a++) do_rd(4'(a), "R5 page0 after unmapped");

    // R6, R7: set beats clear
    do_wr(4'd15, 8'hFF, 8'h00, "R8 all mask");
    do_wr(4'd7, 8'hFF, 8'h00, "R6 clear all");
    do_wr(4'd7, 8'h05, 8'h01, "R6 set wins over clear");
    do_rd(4'd7, "R6 status after collision");
    do_wr(4'd7, 8'h00, 8'h30, "R7 event set");
    do_rd(4'd7, "R7 status after events");

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [3:0] a;
      logic [7:0] d, s;
      a = ($urandom % 5 == 0) ? 4'd0 : 4'($urandom);
      d = 8'($urandom);
      s = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
      if ($urandom % 4 == 0) a = 4'd7;
      do_wr(a, d, s, "R3 random write");
      do_rd(4'($urandom), "R4 random read");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule